// File: doc/BRIEF.md
# Parallel Converter Bus Timing Sequencer

This block sits on the host side of a parallel bus that connects to a quad-channel, 12-bit voltage-output converter. A client hands it one command at a time over a valid/ready interface. The sequencer then drives the converter's control pins with correctly timed cycles. The pins are an active-low select, a read/write line, a 2-bit channel address, an active-low load strobe, an active-low reset strobe and the host's data-bus output enable. When the command finishes, the block returns a one-cycle response pulse. For a read, that pulse carries the data sampled from the converter.

Every minimum pulse width and delay is given as a nanosecond parameter. Each one is converted to whole clock cycles by ceiling division with the clock-period parameter, so retargeting to another clock only changes parameters. The block supports five commands:

- a channel write;
- a channel write that also updates the outputs;
- a load of all outputs;
- a readback;
- a reset of the converter.

After a readback, the host does not drive the bus again until the converter's release time has passed.

Top module: `dac_bus_seq`

## Requirements
- R1: While the block reset `rst_n` is low, and in the cycle it is released, `dac_cs_n`, `dac_ld_n` and `dac_rst_n` are high, `bus_oe` is high, `cmd_ready` is high, `rsp_valid` is low and `rsp_data` is zero. A reset in the middle of a command abandons it.
- R2: A time parameter `t` converts to `max(1, ceil(t / CLK_PERIOD_NS))` cycles. At the default 8 ns period this gives: write select 10, load setup 9, load hold 4, load-all 22, reset 18, read select 17, select-to-data 20, release 25.
- R3: The write command is code 0. It drives address, `dac_rw_n`=0 and the data for one cycle with select high. It then holds `dac_cs_n` low for the write-select count with address, `dac_rw_n` and data stable, and follows with one hold cycle. `dac_ld_n` and `dac_rst_n` stay high.
- R4: The write-and-load command is code 1. It keeps select low for the larger of write-select and load-setup counts. `dac_ld_n` is low for the last load-setup cycles of that strobe and for load-hold cycles after select rises.
- R5: The load-all command is code 2. It pulls `dac_ld_n` low for the load-all count while `dac_cs_n` stays high.
- R6: The reset command is code 4. It pulls `dac_rst_n` low for the reset count while `dac_cs_n` and `dac_ld_n` stay high.
- R7: The readback command is code 3. It drops `bus_oe` one cycle before select falls and drives `dac_rw_n`=1. It holds select low for the larger of the read-select and select-to-data counts, and samples `bus_din` on the last cycle of that strobe.
- R8: After a readback, `bus_oe` stays low for one hold cycle plus the release count after select rises. It returns high in the response cycle.
- R9: `cmd_ready` is high only when no command is running, and a command is taken on `cmd_valid` with `cmd_ready`. `rsp_valid` is a one-cycle pulse. It arrives N+H+T+2 cycles after acceptance, where N is the strobe count, H the hold count (the load-hold count for code 1, else 1) and T the release count (readback only, else 0).
- R10: `rsp_data` holds the last readback value. Commands other than readback leave it unchanged.
- R11: Codes 5 to 7 cause no pin activity and give `rsp_valid` in the first cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_op | input | 3 | Command code (0 write, 1 write-and-load, 2 load-all, 3 readback, 4 reset) |
| cmd_addr | input | 2 | Target channel |
| cmd_data | input | 12 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 12 | Last readback value |
| dac_cs_n | output | 1 | Converter select, active low |
| dac_rw_n | output | 1 | High for read, low for write |
| dac_addr | output | 2 | Channel address to the converter |
| dac_ld_n | output | 1 | Output-update strobe, active low |
| dac_rst_n | output | 1 | Converter reset strobe, active low |
| bus_oe | output | 1 | Host drives the data bus when high |
| bus_dout | output | 12 | Host data toward the converter |
| bus_din | input | 12 | Data bus as seen from the converter |

## Verification
The response pulse is due at a fixed cycle after acceptance: 13 cycles for a write, 16 for write-and-load, 25 for load-all, 21 for reset, 48 for readback and 1 for an undefined code. The bench counts cycles from the accepting edge and samples every pin at the falling edge. It records exactly how many cycles each strobe is low, where the load strobe sits relative to the select edge, and at which cycle the response appears. The converter model in the bench presents valid read data only from the select-to-data count onward. A sample taken before the last strobe cycle therefore returns a marker value, not the expected data.

// File: rtl/dac_seq_pkg.sv
// Package: shared command codes, phase encoding and the ns-to-cycle conversion.
// Assumes positive clock period; all conversions are elaboration-time constants.
package dac_seq_pkg;

    typedef enum logic [2:0] {
        OP_WRITE      = 3'd0,
        OP_WRITE_LOAD = 3'd1,
        OP_LOAD_ALL   = 3'd2,
        OP_READ       = 3'd3,
        OP_RESET      = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_SETUP  = 3'd1,
        S_STROBE = 3'd2,
        S_HOLD   = 3'd3,
        S_TURN   = 3'd4,
        S_DONE   = 3'd5
    } phase_e;

    // Ceiling division of a nanosecond limit by the period, never below one cycle.
    function automatic int ns_to_cyc(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_phase_timer.sv
// Module: down-counter that times the current bus phase.
// A load sets the remaining count (length-1); zero flags the phase's last cycle.
module dac_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);

    // Count down toward zero; a load overrides.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/dac_seq_fsm.sv
// Module: phase sequencer. Accepts one command in IDLE, then steps through
// SETUP, STROBE, HOLD, optional TURN and DONE using the phase timer.
// Assumes all lengths are at least one cycle (guaranteed by ns_to_cyc).
module dac_seq_fsm
    import dac_seq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 12,
    parameter int CNT_W  = 5,
    parameter int STB_WR = 1,
    parameter int STB_WL = 1,
    parameter int STB_LD = 1,
    parameter int STB_RD = 1,
    parameter int STB_RS = 1,
    parameter int HLD_WL = 1,
    parameter int TURN_C = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              t_zero,
    output phase_e            state,
    output logic [2:0]        op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              t_load,
    output logic [CNT_W-1:0]  t_val
);

    localparam logic [CNT_W-1:0] L_WR   = CNT_W'(STB_WR - 1);
    localparam logic [CNT_W-1:0] L_WL   = CNT_W'(STB_WL - 1);
    localparam logic [CNT_W-1:0] L_LD   = CNT_W'(STB_LD - 1);
    localparam logic [CNT_W-1:0] L_RD   = CNT_W'(STB_RD - 1);
    localparam logic [CNT_W-1:0] L_RS   = CNT_W'(STB_RS - 1);
    localparam logic [CNT_W-1:0] L_HWL  = CNT_W'(HLD_WL - 1);
    localparam logic [CNT_W-1:0] L_TURN = CNT_W'(TURN_C - 1);
    localparam logic [2:0]       OP_MAX = OP_RESET;

    phase_e           nxt;
    logic [CNT_W-1:0] stb_val;
    logic [CNT_W-1:0] hld_val;

    // Strobe and hold lengths for the latched command.
    always_comb begin
        case (op_q)
            OP_WRITE:      stb_val = L_WR;
            OP_WRITE_LOAD: stb_val = L_WL;
            OP_LOAD_ALL:   stb_val = L_LD;
            OP_READ:       stb_val = L_RD;
            default:       stb_val = L_RS;
        endcase
        hld_val = (op_q == OP_WRITE_LOAD) ? L_HWL : '0;
    end

    // Next phase and timer load for each phase exit.
    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        case (state)
            S_IDLE: if (cmd_valid) begin
                t_load = 1'b1;
                nxt    = (cmd_op <= OP_MAX) ? S_SETUP : S_DONE;
            end
            S_SETUP: if (t_zero) begin
                nxt = S_STROBE; t_load = 1'b1; t_val = stb_val;
            end
            S_STROBE: if (t_zero) begin
                nxt = S_HOLD; t_load = 1'b1; t_val = hld_val;
            end
            S_HOLD: if (t_zero) begin
                if (op_q == OP_READ) begin
                    nxt = S_TURN; t_load = 1'b1; t_val = L_TURN;
                end else begin
                    nxt = S_DONE;
                end
            end
            S_TURN:  if (t_zero) nxt = S_DONE;
            default: nxt = S_IDLE;
        endcase
    end

    // Phase register and command latch on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && cmd_valid) begin
                op_q   <= cmd_op;
                addr_q <= cmd_addr;
                data_q <= cmd_data;
            end
        end
    end

endmodule

// File: rtl/dac_rd_capture.sv
// Module: readback data register. Loads the bus value when told to sample;
// otherwise holds, so non-read commands leave the last result intact.
module dac_rd_capture #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // Capture on the sample strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (sample)
            dout <= din;
    end

endmodule

// File: rtl/dac_bus_seq.sv
// Module: top of the converter bus sequencer. Converts ns limits to cycle
// counts, runs the phase FSM and decodes the bus pins from phase and timer.
// Assumes the converter samples the pins asynchronously; pins are decoded
// from registered state and timer only.
module dac_bus_seq
    import dac_seq_pkg::*;
#(
    parameter int ADDR_W        = 2,
    parameter int DATA_W        = 12,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_WCS_NS      = 80,
    parameter int T_LS_NS       = 70,
    parameter int T_LH_NS       = 30,
    parameter int T_LDW_NS      = 170,
    parameter int T_RST_NS      = 140,
    parameter int T_RCS_NS      = 130,
    parameter int T_CSD_NS      = 160,
    parameter int T_DZ_NS       = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              dac_cs_n,
    output logic              dac_rw_n,
    output logic [ADDR_W-1:0] dac_addr,
    output logic              dac_ld_n,
    output logic              dac_rst_n,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din
);

    localparam int WCS_C = ns_to_cyc(T_WCS_NS, CLK_PERIOD_NS);
    localparam int LS_C  = ns_to_cyc(T_LS_NS,  CLK_PERIOD_NS);
    localparam int LH_C  = ns_to_cyc(T_LH_NS,  CLK_PERIOD_NS);
    localparam int LDW_C = ns_to_cyc(T_LDW_NS, CLK_PERIOD_NS);
    localparam int RST_C = ns_to_cyc(T_RST_NS, CLK_PERIOD_NS);
    localparam int RCS_C = ns_to_cyc(T_RCS_NS, CLK_PERIOD_NS);
    localparam int CSD_C = ns_to_cyc(T_CSD_NS, CLK_PERIOD_NS);
    localparam int DZ_C  = ns_to_cyc(T_DZ_NS,  CLK_PERIOD_NS);
    localparam int WL_C  = max2(WCS_C, LS_C);
    localparam int RD_C  = max2(RCS_C, CSD_C);
    localparam int MAX_C = max2(max2(max2(WL_C, LDW_C), max2(RST_C, RD_C)),
                                max2(LH_C, DZ_C));
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LS_V = CNT_W'(LS_C);

    phase_e            state;
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic [CNT_W-1:0]  t_cnt;
    logic              t_zero;
    logic              in_bus;
    logic              is_rd;
    logic              is_wr;

    dac_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
        .cnt(t_cnt), .zero(t_zero)
    );

    dac_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .STB_WR(WCS_C), .STB_WL(WL_C), .STB_LD(LDW_C), .STB_RD(RD_C),
        .STB_RS(RST_C), .HLD_WL(LH_C), .TURN_C(DZ_C)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .t_zero(t_zero),
        .state(state), .op_q(op_q), .addr_q(addr_q), .data_q(data_q),
        .t_load(t_load), .t_val(t_val)
    );

    dac_rd_capture #(.DATA_W(DATA_W)) cap_i (
        .clk(clk), .rst_n(rst_n),
        .sample(state == S_STROBE && is_rd && t_zero),
        .din(bus_din), .dout(rsp_data)
    );

    // Pin decode from the current phase, command and remaining strobe count.
    always_comb begin
        in_bus    = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
        is_rd     = (op_q == OP_READ);
        is_wr     = (op_q == OP_WRITE) || (op_q == OP_WRITE_LOAD);
        dac_cs_n  = !(state == S_STROBE && (is_wr || is_rd));
        dac_rw_n  = !(in_bus && is_wr);
        dac_ld_n  = !((state == S_STROBE && op_q == OP_LOAD_ALL) ||
                      (state == S_STROBE && op_q == OP_WRITE_LOAD && t_cnt < LS_V) ||
                      (state == S_HOLD   && op_q == OP_WRITE_LOAD));
        dac_rst_n = !(state == S_STROBE && op_q == OP_RESET);
        bus_oe    = !(is_rd && (in_bus || state == S_TURN));
        dac_addr  = addr_q;
        bus_dout  = data_q;
        cmd_ready = (state == S_IDLE);
        rsp_valid = (state == S_DONE);
    end

endmodule

// File: rtl/dac_bus_seq_chk.sv
// Module: protocol checker bound to the sequencer top. Watches the pins and
// the handshake only; windows too long to unroll are timed with counters.
module dac_bus_seq_chk
    import dac_seq_pkg::*;
#(
    parameter int ADDR_W        = 2,
    parameter int DATA_W        = 12,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_WCS_NS      = 80,
    parameter int T_DZ_NS       = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic              dac_cs_n,
    input logic              dac_rw_n,
    input logic [ADDR_W-1:0] dac_addr,
    input logic              dac_ld_n,
    input logic              dac_rst_n,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_dout
);

    localparam int WCS_C = ns_to_cyc(T_WCS_NS, CLK_PERIOD_NS);
    localparam int DZ_C  = ns_to_cyc(T_DZ_NS,  CLK_PERIOD_NS);

    int cs_run;
    int rel_cnt;

    // Length of the current select-low run.
    always_ff @(posedge clk) begin
        if (!rst_n || dac_cs_n) cs_run <= 0;
        else                    cs_run <= cs_run + 1;
    end

    // Cycles since a read select ended, saturating at the release count.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rel_cnt <= DZ_C;
        else if (!dac_cs_n && dac_rw_n) rel_cnt <= 0;
        else if (rel_cnt < DZ_C)       rel_cnt <= rel_cnt + 1;
    end

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (dac_cs_n && dac_ld_n && dac_rst_n));

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_no_drive_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && dac_rw_n) |-> !bus_oe);

    assert_bus_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && $past(!dac_cs_n)) |->
        ($stable(dac_addr) && $stable(dac_rw_n) && $stable(bus_dout)));

    assert_cs_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> (cs_run >= WCS_C));

    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> (rel_cnt >= DZ_C));

endmodule

bind dac_bus_seq dac_bus_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_WCS_NS(T_WCS_NS), .T_DZ_NS(T_DZ_NS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .dac_cs_n(dac_cs_n), .dac_rw_n(dac_rw_n), .dac_addr(dac_addr),
    .dac_ld_n(dac_ld_n), .dac_rst_n(dac_rst_n), .bus_oe(bus_oe),
    .bus_dout(bus_dout)
);

// File: tb/dac_bus_seq_tb_top.sv
// Bench: walks a vector table of commands, measures every strobe at the
// falling edge, then runs directed reset and undefined-code tests.
module dac_bus_seq_tb_top;

    localparam int PER = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_WCS = cyc(80);
    localparam int E_LS  = cyc(70);
    localparam int E_LH  = cyc(30);
    localparam int E_LDW = cyc(170);
    localparam int E_RST = cyc(140);
    localparam int E_RCS = cyc(130);
    localparam int E_CSD = cyc(160);
    localparam int E_DZ  = cyc(200);
    localparam int E_WL  = (E_WCS > E_LS) ? E_WCS : E_LS;
    localparam int E_RD  = (E_RCS > E_CSD) ? E_RCS : E_CSD;

    // Vector: op[16:14], addr[13:12], data[11:0] (read: value the converter returns)
    localparam int NV = 8;
    localparam logic [16:0] VEC [NV] = '{
        {3'd0, 2'd0, 12'h123}, {3'd0, 2'd3, 12'hFFF},
        {3'd1, 2'd1, 12'h800}, {3'd2, 2'd0, 12'h000},
        {3'd3, 2'd2, 12'hA5C}, {3'd4, 2'd0, 12'h000},
        {3'd3, 2'd1, 12'h3C1}, {3'd0, 2'd2, 12'h000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_addr = '0;
    logic [11:0] cmd_data = '0;
    logic        rsp_valid;
    logic [11:0] rsp_data;
    logic        dac_cs_n, dac_rw_n, dac_ld_n, dac_rst_n, bus_oe;
    logic [1:0]  dac_addr;
    logic [11:0] bus_dout;
    logic [11:0] bus_din = 12'hBAD;

    int errors = 0;
    int checks = 0;
    int m_cs, m_ld, m_ld_in_cs, m_ld_after, m_rst, m_oe, m_lat, m_busy_ready, m_rw;
    logic [1:0]  m_addr;
    logic [11:0] m_dout, m_rsp;

    always #(PER/2) clk = ~clk;

    dac_bus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dac_cs_n(dac_cs_n),
        .dac_rw_n(dac_rw_n), .dac_addr(dac_addr), .dac_ld_n(dac_ld_n),
        .dac_rst_n(dac_rst_n), .bus_oe(bus_oe), .bus_dout(bus_dout),
        .bus_din(bus_din)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one command and measure pins each falling edge until the response.
    task automatic run_cmd(input logic [2:0] op, input logic [1:0] a, input logic [11:0] d);
        bit seen_cs;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        m_cs = 0; m_ld = 0; m_ld_in_cs = 0; m_ld_after = 0; m_rst = 0; m_oe = 0;
        m_lat = 0; m_busy_ready = 0; m_rw = 1; m_addr = '0; m_dout = '0; seen_cs = 0;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (!dac_cs_n) begin
                if (!seen_cs) begin m_addr = dac_addr; m_dout = bus_dout; m_rw = dac_rw_n; end
                seen_cs = 1; m_cs++;
                if (!dac_ld_n) m_ld_in_cs++;
            end else if (seen_cs && !dac_ld_n) m_ld_after++;
            if (!dac_ld_n) m_ld++;
            if (!dac_rst_n) m_rst++;
            if (!bus_oe) m_oe++;
            // converter model: read data valid only once select-to-data has elapsed
            bus_din = (!dac_cs_n && dac_rw_n && m_cs >= E_CSD) ? d : 12'hBAD;
            if (rsp_valid) begin m_lat = k; m_rsp = rsp_data; break; end
            if (cmd_ready) m_busy_ready++;
        end
    endtask

    initial begin
        #(200000 * PER);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [11:0] last_rd;
        int n, h, t, exp_cs, exp_ld, exp_rst, exp_oe;
        string tag;
        last_rd = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "cs_n", dac_cs_n, 1); chk("R1", "ld_n", dac_ld_n, 1);
        chk("R1", "rst_o", dac_rst_n, 1); chk("R1", "oe", bus_oe, 1);
        chk("R1", "ready", cmd_ready, 1); chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "rsp_data", rsp_data, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] op; logic [1:0] a; logic [11:0] d;
            {op, a, d} = VEC[i];
            run_cmd(op, a, d);
            exp_cs = 0; exp_ld = 0; exp_rst = 0; exp_oe = 0; h = 1; t = 0;
            case (op)
                3'd0: begin tag = "R3"; n = E_WCS; exp_cs = n; end
                3'd1: begin tag = "R4"; n = E_WL; exp_cs = n; h = E_LH; exp_ld = E_LS + E_LH; end
                3'd2: begin tag = "R5"; n = E_LDW; exp_ld = n; end
                3'd3: begin tag = "R7"; n = E_RD; exp_cs = n; t = E_DZ; exp_oe = 2 + n + t; end
                default: begin tag = "R6"; n = E_RST; exp_rst = n; end
            endcase
            chk(tag, "select low cycles", m_cs, exp_cs);
            chk(tag, "load low cycles", m_ld, exp_ld);
            chk(tag, "reset low cycles", m_rst, exp_rst);
            chk("R8", "oe low cycles", m_oe, exp_oe);
            chk("R2", "response latency", m_lat, n + h + t + 2);
            chk("R9", "ready high while busy", m_busy_ready, 0);
            if (op == 3'd1) begin
                chk("R4", "load low during select", m_ld_in_cs, E_LS);
                chk("R4", "load low after select", m_ld_after, E_LH);
            end
            if (exp_cs != 0) chk(tag, "address at select", m_addr, a);
            if (op <= 3'd1) begin
                chk("R3", "write data", m_dout, d);
                chk("R3", "rw_n at select", m_rw, 0);
            end
            if (op == 3'd3) begin
                chk("R7", "rw_n at select", m_rw, 1);
                last_rd = d;
            end
            chk("R10", "rsp_data", m_rsp, last_rd);
        end

        // R11: undefined code gives no pin activity and a next-cycle response
        run_cmd(3'd6, 2'd1, 12'h555);
        chk("R11", "latency", m_lat, 1);
        chk("R11", "select low", m_cs, 0);
        chk("R11", "strobes low", m_ld + m_rst + m_oe, 0);
        chk("R10", "rsp_data after undefined", m_rsp, last_rd);

        // R1: reset in the middle of a load-all abandons it
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_addr = '0; cmd_data = '0;
        @(negedge clk); cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5", "load low mid command", dac_ld_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "ld_n after mid reset", dac_ld_n, 1);
        chk("R1", "ready after mid reset", cmd_ready, 1);
        chk("R1", "rsp_data after mid reset", rsp_data, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "idle after release", dac_ld_n & dac_cs_n & bus_oe, 1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule